// File: doc/BRIEF.md
# Repeated-Instruction Vector Lane Sequencer

The sequencer takes wide, pre-decoded lane instructions from a valid/ready stream and replays each one over a run of consecutive vector elements. An instruction carries a lane-control code, a repeat count and four slice slots. Each slot pairs an arithmetic operation with a memory (load/store) operation, and either one may be a nop. For every element step the sequencer raises a strobe for each non-nop operation in every slice. Each strobe comes with the opcode, the three register indices and the element pointer of that operation. After the last step it pulses `done` and falls through to the next instruction.

There is no scheduling and no dependency check. A step issues in every cycle in which the downstream `dn_ready` is high, whatever registers the previous instruction wrote. Software must keep a dependent operation out of the instruction that follows directly. Execution units, register storage and branch handling sit outside the block. The lane-control code is only handed on with `done`.

Instruction layout (bit 0 = LSB): `[137:136]` lane control, `[135:128]` repeat count, slice s in `[32s+31:32s]`. Inside a slot, the arithmetic half is `[31:16]` and the memory half is `[15:0]`. Each half is `{op[2:0], vec, rd[3:0], ra[3:0], rb[3:0]}`, so the op code is in bits 15..13 of the half and `vec` is bit 12.

Top module: `vlane_seq`

## Requirements
- R1: `in_ready` is low while reset is asserted and for the synchronizer cycles after release. Afterwards it is high exactly when no instruction is in progress. An instruction is taken on a clock edge with `in_valid` and `in_ready` both high.
- R2: An instruction with repeat count N>0 issues exactly N element steps. The first step may issue in the cycle after acceptance. A step issues in a cycle where `dn_ready` is high, and no strobe is raised in a cycle where it is low.
- R3: In a step, slice s raises `a_stb[s]` or `m_stb[s]` only if that half's op code is non-zero. The op code is presented on `a_op`/`m_op` (3 bits per slice). `{rd,ra,rb}` is presented on `a_regs`/`m_regs` (12 bits per slice).
- R4: For an operation with `vec`=1, the element pointer equals the number of steps of the current instruction already issued, modulo 32. It starts at 0 for every new instruction.
- R5: For an operation with `vec`=0 (scalar operands), the element pointer stays 0. A repeat count of 1 gives exactly one strobe.
- R6: `a_pair[s]` is high with a strobe whose arithmetic code is 3 or 4, the packed two-lane 32-bit integer ops. It is low for codes 1 and 2, the 64-bit floating-point ops.
- R7: `done` is high for one cycle, the cycle after the final step. `done_ctl` then carries the instruction's lane-control code. `in_ready` is high in the following cycle.
- R8: A repeat count of 0 raises no strobe. `done` follows in the cycle after acceptance.
- R9: Steps are never held back by register dependences. An instruction that reads registers written by the one just before still issues a step in every cycle with `dn_ready` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Sequencer can take an instruction |
| in_instr | input | 138 | Instruction word |
| dn_ready | input | 1 | Downstream units can take a step |
| a_stb | output | 4 | Arithmetic strobe per slice |
| a_op | output | 12 | Arithmetic op code per slice |
| a_regs | output | 48 | Arithmetic {rd,ra,rb} per slice |
| a_ptr | output | 20 | Arithmetic element pointer per slice |
| a_pair | output | 4 | Packed 2x32-bit arithmetic per slice |
| m_stb | output | 4 | Memory strobe per slice |
| m_op | output | 12 | Memory op code per slice |
| m_regs | output | 48 | Memory {rd,ra,rb} per slice |
| m_ptr | output | 20 | Memory element pointer per slice |
| done | output | 1 | Instruction finished |
| done_ctl | output | 2 | Lane-control code of the finished instruction |

## Verification
An instruction taken at edge k may issue its first step in the cycle after k. Each further step follows in the next cycle with `dn_ready` high. `done` appears one cycle after the last step, or one cycle after acceptance for a zero count, and `in_ready` rises one cycle after `done`. The bench's behavioural model advances by exactly these rules each clock. The bench drives inputs on the falling edge, waits a short settling delay and compares every output against the model before the next rising edge, so each result is checked in the cycle it is due.

// File: rtl/vlane_seq_pkg.sv
package vlane_seq_pkg;

  localparam int OP_W   = 3;
  localparam int REG_W  = 4;
  localparam int HALF_W = OP_W + 1 + 3 * REG_W;
  localparam int SLOT_W = 2 * HALF_W;
  localparam int CTL_W  = 2;

  localparam logic [OP_W-1:0] OP_NOP   = 3'd0;
  localparam logic [OP_W-1:0] AOP_XADD = 3'd3;
  localparam logic [OP_W-1:0] AOP_XSUB = 3'd4;

  typedef struct packed {
    logic [OP_W-1:0]  op;
    logic             vec;
    logic [REG_W-1:0] rd;
    logic [REG_W-1:0] ra;
    logic [REG_W-1:0] rb;
  } half_t;

  typedef struct packed {
    half_t arith;
    half_t mem;
  } slot_t;

  typedef enum logic [1:0] {SQ_IDLE, SQ_RUN, SQ_FIN} seq_st_e;

  function automatic logic is_packed_op(input logic [OP_W-1:0] op);
    return (op == AOP_XADD) || (op == AOP_XSUB);
  endfunction

endpackage

// File: rtl/vlane_seq_ctrl.sv
module vlane_seq_ctrl
  import vlane_seq_pkg::*;
#(
  parameter int RPT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [RPT_W-1:0] rpt,
  input  logic [CTL_W-1:0] ctl,
  input  logic             dn_ready,
  output logic             in_ready,
  output logic             start,
  output logic             issue,
  output logic             done,
  output logic [CTL_W-1:0] done_ctl
);

  seq_st_e          st_q, st_d;
  logic [RPT_W-1:0] left_q, left_d;
  logic [CTL_W-1:0] ctl_q, ctl_d;
  logic             armed_q;

  assign in_ready = armed_q && (st_q == SQ_IDLE);
  assign start    = in_valid && in_ready;
  assign issue    = (st_q == SQ_RUN) && dn_ready;
  assign done     = (st_q == SQ_FIN);
  assign done_ctl = ctl_q;

  always_comb begin
    st_d   = st_q;
    left_d = left_q;
    ctl_d  = ctl_q;
    case (st_q)
      SQ_IDLE: begin
        if (start) begin
          left_d = rpt;
          ctl_d  = ctl;
          st_d   = (rpt == '0) ? SQ_FIN : SQ_RUN;
        end
      end
      SQ_RUN: begin
        if (issue) begin
          left_d = left_q - 1'b1;
          if (left_q == RPT_W'(1)) st_d = SQ_FIN;
        end
      end
      SQ_FIN:  st_d = SQ_IDLE;
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= SQ_IDLE;
      left_q  <= '0;
      ctl_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      left_q  <= left_d;
      ctl_q   <= ctl_d;
      armed_q <= 1'b1;
    end
  end

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && in_ready));

  // R2
  run_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SQ_RUN) |-> (left_q != '0));

  // R8
  zero_rpt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && (rpt == '0)) |=> (done && !issue));

  // R1
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue |-> !in_ready);

endmodule

// File: rtl/vlane_seq_half.sv
module vlane_seq_half
  import vlane_seq_pkg::*;
#(
  parameter int PTR_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               issue,
  input  half_t              half_in,
  output logic               stb,
  output logic [OP_W-1:0]    op,
  output logic [3*REG_W-1:0] regs,
  output logic [PTR_W-1:0]   ptr
);

  half_t            h_q, h_d;
  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic             adv;

  assign adv  = issue && (h_q.op != OP_NOP) && h_q.vec;
  assign stb  = issue && (h_q.op != OP_NOP);
  assign op   = h_q.op;
  assign regs = {h_q.rd, h_q.ra, h_q.rb};
  assign ptr  = ptr_q;

  always_comb begin
    h_d   = h_q;
    ptr_d = ptr_q;
    if (start) begin
      h_d   = half_in;
      ptr_d = '0;
    end else if (adv) begin
      ptr_d = ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_q   <= '0;
      ptr_q <= '0;
    end else begin
      h_q   <= h_d;
      ptr_q <= ptr_d;
    end
  end

  // R4
  ptr_bump_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> (ptr_q == PTR_W'($past(ptr_q) + 1'b1)));

  // R4
  ptr_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (ptr_q == '0));

  // R5
  scalar_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && !h_q.vec) |-> (ptr_q == '0));

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(h_q));

endmodule

// File: rtl/vlane_seq.sv
module vlane_seq
  import vlane_seq_pkg::*;
#(
  parameter int NSLICE = 4,
  parameter int RPT_W  = 8,
  parameter int PTR_W  = 5
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           in_valid,
  output logic                           in_ready,
  input  logic [CTL_W+RPT_W+NSLICE*SLOT_W-1:0] in_instr,
  input  logic                           dn_ready,
  output logic [NSLICE-1:0]              a_stb,
  output logic [NSLICE*OP_W-1:0]         a_op,
  output logic [NSLICE*3*REG_W-1:0]      a_regs,
  output logic [NSLICE*PTR_W-1:0]        a_ptr,
  output logic [NSLICE-1:0]              a_pair,
  output logic [NSLICE-1:0]              m_stb,
  output logic [NSLICE*OP_W-1:0]         m_op,
  output logic [NSLICE*3*REG_W-1:0]      m_regs,
  output logic [NSLICE*PTR_W-1:0]        m_ptr,
  output logic                           done,
  output logic [CTL_W-1:0]               done_ctl
);

  localparam int BODY_W  = NSLICE * SLOT_W;
  localparam int INSTR_W = CTL_W + RPT_W + BODY_W;
  localparam int RG_W    = 3 * REG_W;

  logic [1:0] rsync_q;
  logic       core_rst_n;
  logic       start, issue;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign core_rst_n = rsync_q[1];

  vlane_seq_ctrl #(.RPT_W(RPT_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .in_valid (in_valid),
    .rpt      (in_instr[BODY_W +: RPT_W]),
    .ctl      (in_instr[INSTR_W-1 -: CTL_W]),
    .dn_ready (dn_ready),
    .in_ready (in_ready),
    .start    (start),
    .issue    (issue),
    .done     (done),
    .done_ctl (done_ctl)
  );

  for (genvar s = 0; s < NSLICE; s++) begin : g_slice
    slot_t slot;
    assign slot = slot_t'(in_instr[s*SLOT_W +: SLOT_W]);

    vlane_seq_half #(.PTR_W(PTR_W)) u_arith (
      .clk     (clk),
      .rst_n   (core_rst_n),
      .start   (start),
      .issue   (issue),
      .half_in (slot.arith),
      .stb     (a_stb[s]),
      .op      (a_op[s*OP_W +: OP_W]),
      .regs    (a_regs[s*RG_W +: RG_W]),
      .ptr     (a_ptr[s*PTR_W +: PTR_W])
    );

    vlane_seq_half #(.PTR_W(PTR_W)) u_mem (
      .clk     (clk),
      .rst_n   (core_rst_n),
      .start   (start),
      .issue   (issue),
      .half_in (slot.mem),
      .stb     (m_stb[s]),
      .op      (m_op[s*OP_W +: OP_W]),
      .regs    (m_regs[s*RG_W +: RG_W]),
      .ptr     (m_ptr[s*PTR_W +: PTR_W])
    );

    assign a_pair[s] = a_stb[s] && is_packed_op(a_op[s*OP_W +: OP_W]);
  end

  // R2
  stall_quiet_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    !dn_ready |-> ((a_stb == '0) && (m_stb == '0)));

  // R7
  done_quiet_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    done |-> ((a_stb == '0) && (m_stb == '0) && !in_ready));

endmodule

// File: tb/tb_vlane_seq.sv
`timescale 1ns/1ps
module tb_vlane_seq;
  localparam int NS = 4, RW = 8, PW = 5;
  localparam int IW = 2 + RW + NS * 32;
  localparam int LIMIT = 20000;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic            rst_n, in_valid, in_ready, dn_ready, done;
  logic [IW-1:0]   in_instr;
  logic [NS-1:0]   a_stb, a_pair, m_stb;
  logic [NS*3-1:0] a_op, m_op;
  logic [NS*12-1:0] a_regs, m_regs;
  logic [NS*PW-1:0] a_ptr, m_ptr;
  logic [1:0]      done_ctl;

  vlane_seq dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_instr(in_instr), .dn_ready(dn_ready),
    .a_stb(a_stb), .a_op(a_op), .a_regs(a_regs), .a_ptr(a_ptr), .a_pair(a_pair),
    .m_stb(m_stb), .m_op(m_op), .m_regs(m_regs), .m_ptr(m_ptr),
    .done(done), .done_ctl(done_ctl)
  );

  int checks = 0, errors = 0, cyc = 0;
  int ph = 0, left = 0, step = 0, nseen = 0;
  bit stall_mode = 0, gap_mode = 0;
  logic [IW-1:0] cur = '0;
  logic [IW-1:0] q[$];

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic logic [15:0] hf(input int op, input int vec, input int rd,
                                     input int ra, input int rb);
    return {op[2:0], vec[0], rd[3:0], ra[3:0], rb[3:0]};
  endfunction

  function automatic logic [IW-1:0] mk(input int ctl, input int rpt,
      input logic [31:0] s0, input logic [31:0] s1,
      input logic [31:0] s2, input logic [31:0] s3);
    return {ctl[1:0], rpt[7:0], s3, s2, s1, s0};
  endfunction

  function automatic bit any_op(input logic [IW-1:0] w);
    for (int s = 0; s < NS; s++)
      if (w[s*32+29 +: 3] != 0 || w[s*32+13 +: 3] != 0) return 1;
    return 0;
  endfunction

  task automatic one_cycle();
    int rpt;
    @(negedge clk);
    cyc++;
    dn_ready = stall_mode ? ((cyc % 3) != 1) : 1'b1;
    in_valid = (q.size() > 0) && !(gap_mode && (cyc % 4 == 0));
    in_instr = (q.size() > 0) ? q[0] : '0;
    #1;
    rpt = int'(cur[IW-3 -: 8]);
    chk("R1 in_ready", in_ready, ph == 0);
    chk("R7 done", done, ph == 2);
    if (ph == 2) begin
      chk("R7 done_ctl", done_ctl, cur[IW-1 -: 2]);
      if (rpt == 0) chk("R8 step count", nseen, 0);
      else          chk("R2 step count", nseen, any_op(cur) ? rpt : 0);
    end
    for (int s = 0; s < NS; s++) begin
      logic [15:0] ah, mh;
      bit ea, em;
      ah = cur[s*32+16 +: 16];
      mh = cur[s*32 +: 16];
      ea = (ph == 1) && dn_ready && (ah[15:13] != 0);
      em = (ph == 1) && dn_ready && (mh[15:13] != 0);
      chk("R2 R9 a_stb", a_stb[s], ea);
      chk("R2 R9 m_stb", m_stb[s], em);
      if (ea && a_stb[s]) begin
        chk("R3 a_op", a_op[s*3 +: 3], ah[15:13]);
        chk("R3 a_regs", a_regs[s*12 +: 12], ah[11:0]);
        if (ah[12]) chk("R4 a_ptr", a_ptr[s*PW +: PW], step % 32);
        else        chk("R5 a_ptr", a_ptr[s*PW +: PW], 0);
        chk("R6 a_pair", a_pair[s], (ah[15:13] == 3) || (ah[15:13] == 4));
      end
      if (em && m_stb[s]) begin
        chk("R3 m_op", m_op[s*3 +: 3], mh[15:13]);
        chk("R3 m_regs", m_regs[s*12 +: 12], mh[11:0]);
        if (mh[12]) chk("R4 m_ptr", m_ptr[s*PW +: PW], step % 32);
        else        chk("R5 m_ptr", m_ptr[s*PW +: PW], 0);
      end
    end
    if (ph == 1 && ((a_stb | m_stb) != 0)) nseen++;
    case (ph)
      0: if (in_valid) begin
           cur = q.pop_front();
           step = 0; nseen = 0;
           left = int'(cur[IW-3 -: 8]);
           ph = (left == 0) ? 2 : 1;
         end
      1: if (dn_ready) begin
           step++; left--;
           if (left == 0) ph = 2;
         end
      default: ph = 0;
    endcase
  endtask

  task automatic load_set();
    // vector fmul on slice 0, packed add on slice 1, 32 steps
    q.push_back(mk(0, 32, {hf(1,1,3,2,1), 16'h0}, {hf(3,1,5,7,9), 16'h0}, 0, 0));
    // R5: same ops on scalar registers, single step
    q.push_back(mk(0, 1, {hf(1,0,3,2,1), 16'h0}, {hf(3,0,5,7,9), 16'h0}, 0, 0));
    // R8: zero repeat count
    q.push_back(mk(1, 0, {hf(2,1,1,1,1), hf(1,1,2,2,2)}, 0, 0, 0));
    // loads, stores, wrap past 32 elements
    q.push_back(mk(2, 40, {16'h0, hf(1,1,3,2,1)}, {16'h0, hf(1,1,5,7,9)},
                   {hf(2,1,6,5,3), 16'h0}, {hf(4,0,8,9,10), hf(2,1,8,1,0)}));
    // R9: reads what the previous instruction wrote, back to back
    q.push_back(mk(0, 3, {hf(2,1,4,8,6), hf(2,1,6,1,0)}, 0, 0, {hf(3,1,1,8,8), 16'h0}));
    // all-nop body, lane control value carried on done
    q.push_back(mk(3, 2, 0, 0, 0, 0));
    // longest count
    q.push_back(mk(1, 255, 0, {hf(4,1,15,14,13), hf(2,0,12,11,10)}, 0, 0));
  endtask

  task automatic drain();
    while ((q.size() > 0 || ph != 0) && cyc < LIMIT) one_cycle();
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; dn_ready = 1'b0; in_instr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    chk("R1 in_ready in reset", in_ready, 0);
    chk("R7 done in reset", done, 0);
    chk("R2 strobes in reset", a_stb | m_stb, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    load_set();
    drain();
    stall_mode = 1; gap_mode = 1;
    load_set();
    drain();
    repeat (3) one_cycle();
    if (cyc >= LIMIT) begin
      checks++; errors++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule